// File: doc/BRIEF.md
# Reset Source and Start-up Sequencer

This block collects every reason the core may need to restart and decides the exact cycle on which the core is let go. The reasons are: a power-on event, a brown-out event, leaving programming mode (handled like power-on), an active-low external reset pin, a watchdog time-out, a software reset command, and stack overflow or underflow. The analog detectors, the oscillator start-up counter, the watchdog counter and the stack sit outside. They reach this block only as synchronous strobes or levels.

The external pin passes through a synchroniser and a glitch filter. Only a low level that lasts is taken as a request. Two configuration bits decide whether the pin acts as a reset or as a general-purpose input. After a cold event, a power-up delay counter runs if it is enabled. The core leaves reset only when three conditions hold together: the delay has elapsed, the oscillator reports ready, and the pin is not holding reset. The delay and the oscillator wait keep running while the pin is held low. A long pin hold therefore releases the core as soon as the pin rises. Each cause of a reset is written into a sticky status flag vector that software may overwrite.

Top module: `rst_sequencer`

## Requirements
- R1: `pin_is_gpio_o` is 1 exactly when `cfg_pin_en_i` and `cfg_lvp_i` are both 0. Otherwise the pin acts as a reset input.
- R2: With the pin function enabled, a raw pin low that is sampled on 11 consecutive rising edges drives `core_rst_o` to 1 after the 11th edge. This is 2 synchroniser stages plus FILT_LEN=8 filtered samples plus the output register. A low that lasts fewer than FILT_LEN synchronised samples has no effect on `core_rst_o` or on the flags.
- R3: With the pin function disabled, the pin level has no effect on `core_rst_o` or on flag bit 3.
- R4: A cold event drives `core_rst_o` to 1 after the next edge and holds it there while the event stays high. A cold event is `por_i`, `bor_i`, `prog_exit_i`, or an asynchronous `rst_ni` low. Each cold event restarts the power-up delay.
- R5: With `cfg_pwrt_en_i`=1, the power-up delay finishes on the PWRT_CYCLES-th edge that samples no cold event, and `core_rst_o` falls one edge later. With `cfg_pwrt_en_i`=0, the delay finishes on the first such edge.
- R6: `core_rst_o` is a registered output. It is 0 only if, on the previous edge, all of the following held: no source was active, the delay was finished, `osc_ready_i` was 1, and the pin was not holding reset. `osc_ready_i`=0 therefore keeps the core in reset.
- R7: The delay and the oscillator wait run while the pin is held low. Once both are done, `core_rst_o` falls after the 3rd rising edge following the raw pin going high.
- R8: A one-cycle strobe on `wdt_timeout_i`, `sw_reset_i`, or on `stk_ovf_i`/`stk_unf_i` with `cfg_stk_rst_en_i`=1 drives `core_rst_o` to 1 for one cycle. It does not rerun the power-up delay.
- R9: With `cfg_stk_rst_en_i`=0, stack strobes cause no reset and set no flag.
- R10: The flag bits and their power-on values (the power-on vector is 8'h3C) are:
  - bit 0, cold_n: cleared by power-on or programming exit; power-on value 0.
  - bit 1, brown_n: cleared by brown-out; power-on value 0.
  - bit 2, swr_n: cleared by software reset; power-on value 1.
  - bit 3, pin_n: cleared while the pin holds reset; power-on value 1.
  - bit 4, to_n: cleared by watchdog; power-on value 1.
  - bit 5, pd_n: set by watchdog; power-on value 1.
  - bit 6, ovf: set by an enabled overflow; power-on value 0.
  - bit 7, unf: set by an enabled underflow; power-on value 0.
- R11: Flags change one edge after their cause and otherwise keep their value. `flags_we_i` loads `flags_wdata_i`. A cause in the same cycle as a write overrides the written bit. Causes arriving in the same cycle are all recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, treated as power-on |
| por_i | input | 1 | Power-on event, level |
| bor_i | input | 1 | Brown-out event, level |
| prog_exit_i | input | 1 | Programming-mode exit strobe |
| osc_ready_i | input | 1 | Oscillator start-up finished |
| pin_n_i | input | 1 | Raw external reset pin, active low |
| cfg_pin_en_i | input | 1 | Configuration: pin reset enable |
| cfg_lvp_i | input | 1 | Configuration: low-voltage programming enable |
| cfg_pwrt_en_i | input | 1 | Configuration: power-up delay enable |
| cfg_stk_rst_en_i | input | 1 | Configuration: stack fault reset enable |
| wdt_timeout_i | input | 1 | Watchdog time-out strobe |
| sw_reset_i | input | 1 | Software reset strobe |
| stk_ovf_i | input | 1 | Stack overflow strobe |
| stk_unf_i | input | 1 | Stack underflow strobe |
| flags_we_i | input | 1 | Software write of the flags |
| flags_wdata_i | input | 8 | Flag write data |
| core_rst_o | output | 1 | Synchronous core reset, active high |
| flags_o | output | 8 | Sticky reset cause flags |
| pin_is_gpio_o | output | 1 | Pin works as general-purpose input |

## Verification
The bench builds the block with FILT_LEN=8 and SYNC_STAGES=2, and with PWRT_CYCLES cut to 40. The short delay makes many cold restarts fit in one run. It also lets a pin hold of 60 cycles outlast the delay, so the release on the pin's rising edge can be timed exactly. With FILT_LEN at 8, pulses of 5 and 7 cycles test the filter boundary against a 30-cycle hold.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int FLAG_W = 8;

  localparam int F_COLD_N  = 0;
  localparam int F_BROWN_N = 1;
  localparam int F_SWR_N   = 2;
  localparam int F_PIN_N   = 3;
  localparam int F_TO_N    = 4;
  localparam int F_PD_N    = 5;
  localparam int F_OVF     = 6;
  localparam int F_UNF     = 7;

  localparam logic [FLAG_W-1:0] FLAG_POR = 8'h3C;

  typedef struct packed {
    logic cold;
    logic brown;
    logic swr;
    logic pin;
    logic wdt;
    logic ovf;
    logic unf;
  } rsq_evt_t;
endpackage

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  output logic pin_sync_o,
  output logic pin_low_o
);
  localparam int CNT_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   low_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b1;
        else         sync_q[i] <= pin_n_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b1;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  assign pin_sync_o = sync_q[SYNC_STAGES-1];

  // assert after FILT_LEN consecutive low samples, release on the first high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      low_q <= 1'b0;
    end else if (pin_sync_o) begin
      cnt_q <= '0;
      low_q <= 1'b0;
    end else if (cnt_q == CNT_MAX) begin
      low_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pin_low_o = low_q;
endmodule

// File: rtl/rsq_pwrup_timer.sv
module rsq_pwrup_timer #(
  parameter int PWRT_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cold_i,
  input  logic enable_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(PWRT_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWRT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cold_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (!enable_i || cnt_q == CNT_LAST) done_q <= 1'b1;
      else                                cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/rsq_cause_flags.sv
module rsq_cause_flags
  import rsq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rsq_evt_t          evt_i,
  input  logic              we_i,
  input  logic [FLAG_W-1:0] wdata_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = we_i ? wdata_i : flags_q;
    if (evt_i.cold)  flags_d = FLAG_POR;
    if (evt_i.brown) flags_d[F_BROWN_N] = 1'b0;
    if (evt_i.swr)   flags_d[F_SWR_N]   = 1'b0;
    if (evt_i.pin)   flags_d[F_PIN_N]   = 1'b0;
    if (evt_i.wdt) begin
      flags_d[F_TO_N] = 1'b0;
      flags_d[F_PD_N] = 1'b1;
    end
    if (evt_i.ovf)   flags_d[F_OVF]     = 1'b1;
    if (evt_i.unf)   flags_d[F_UNF]     = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) flags_q <= FLAG_POR;
    else         flags_q <= flags_d;

  assign flags_o = flags_q;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rsq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8,
  parameter int PWRT_CYCLES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic              prog_exit_i,
  input  logic              osc_ready_i,
  input  logic              pin_n_i,
  input  logic              cfg_pin_en_i,
  input  logic              cfg_lvp_i,
  input  logic              cfg_pwrt_en_i,
  input  logic              cfg_stk_rst_en_i,
  input  logic              wdt_timeout_i,
  input  logic              sw_reset_i,
  input  logic              stk_ovf_i,
  input  logic              stk_unf_i,
  input  logic              flags_we_i,
  input  logic [FLAG_W-1:0] flags_wdata_i,
  output logic              core_rst_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              pin_is_gpio_o
);
  logic     pin_func_en, pin_sync, pin_low, pin_hold;
  logic     cold, stk_ovf_hit, stk_unf_hit, warm;
  logic     pwrt_done, hold_d, core_rst_q;
  rsq_evt_t evt;

  assign pin_func_en   = cfg_pin_en_i | cfg_lvp_i;
  assign pin_is_gpio_o = ~pin_func_en;

  rsq_pin_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_LEN    (FILT_LEN)
  ) u_pin_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_n_i    (pin_n_i),
    .pin_sync_o (pin_sync),
    .pin_low_o  (pin_low)
  );

  // unfiltered release so a long hold ends on the pin edge
  assign pin_hold = pin_func_en & pin_low & ~pin_sync;

  assign cold        = por_i | bor_i | prog_exit_i;
  assign stk_ovf_hit = cfg_stk_rst_en_i & stk_ovf_i;
  assign stk_unf_hit = cfg_stk_rst_en_i & stk_unf_i;
  assign warm        = wdt_timeout_i | sw_reset_i | stk_ovf_hit | stk_unf_hit;

  rsq_pwrup_timer #(
    .PWRT_CYCLES (PWRT_CYCLES)
  ) u_pwrup_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cold_i   (cold),
    .enable_i (cfg_pwrt_en_i),
    .done_o   (pwrt_done)
  );

  assign hold_d = cold | warm | ~pwrt_done | ~osc_ready_i | pin_hold;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) core_rst_q <= 1'b1;
    else         core_rst_q <= hold_d;

  assign core_rst_o = core_rst_q;

  always_comb begin
    evt.cold  = por_i | prog_exit_i;
    evt.brown = bor_i;
    evt.swr   = sw_reset_i;
    evt.pin   = pin_hold;
    evt.wdt   = wdt_timeout_i;
    evt.ovf   = stk_ovf_hit;
    evt.unf   = stk_unf_hit;
  end

  rsq_cause_flags u_cause_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .we_i    (flags_we_i),
    .wdata_i (flags_wdata_i),
    .flags_o (flags_o)
  );
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
  parameter int FILT_LEN    = 8,
  parameter int PWRT_CYCLES = 1024
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_i,
  input logic       bor_i,
  input logic       prog_exit_i,
  input logic       osc_ready_i,
  input logic       pin_n_i,
  input logic       cfg_pin_en_i,
  input logic       cfg_lvp_i,
  input logic       cfg_pwrt_en_i,
  input logic       cfg_stk_rst_en_i,
  input logic       wdt_timeout_i,
  input logic       sw_reset_i,
  input logic       stk_ovf_i,
  input logic       stk_unf_i,
  input logic       flags_we_i,
  input logic       core_rst_o,
  input logic [7:0] flags_o
);
  int pin_low_cnt;
  int since_cold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_low_cnt <= 0;
      since_cold  <= 0;
    end else begin
      if ((cfg_pin_en_i || cfg_lvp_i) && !pin_n_i)
        pin_low_cnt <= (pin_low_cnt < FILT_LEN + 8) ? pin_low_cnt + 1 : pin_low_cnt;
      else
        pin_low_cnt <= 0;
      if (por_i || bor_i || prog_exit_i) since_cold <= 0;
      else if (since_cold <= PWRT_CYCLES) since_cold <= since_cold + 1;
    end
  end

  a_r2_pin_hold_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_low_cnt >= FILT_LEN + 3) |-> core_rst_o);

  a_r4_cold_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i || bor_i || prog_exit_i) |=> core_rst_o);

  a_r5_delay_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_pwrt_en_i && since_cold <= PWRT_CYCLES) |-> core_rst_o);

  a_r6_osc_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_ready_i |=> core_rst_o);

  a_r8_warm_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_timeout_i || sw_reset_i || (cfg_stk_rst_en_i && (stk_ovf_i || stk_unf_i))) |=> core_rst_o);

  a_r9_stk_off_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_stk_rst_en_i && stk_ovf_i && !flags_o[6] && !flags_we_i) |=> !flags_o[6]);

  a_r10_wdt_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_timeout_i |=> (!flags_o[4] && flags_o[5]));

  a_r11_sw_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_reset_i |=> !flags_o[2]);
endmodule

bind rst_sequencer rst_sequencer_chk #(
  .FILT_LEN    (FILT_LEN),
  .PWRT_CYCLES (PWRT_CYCLES)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .por_i            (por_i),
  .bor_i            (bor_i),
  .prog_exit_i      (prog_exit_i),
  .osc_ready_i      (osc_ready_i),
  .pin_n_i          (pin_n_i),
  .cfg_pin_en_i     (cfg_pin_en_i),
  .cfg_lvp_i        (cfg_lvp_i),
  .cfg_pwrt_en_i    (cfg_pwrt_en_i),
  .cfg_stk_rst_en_i (cfg_stk_rst_en_i),
  .wdt_timeout_i    (wdt_timeout_i),
  .sw_reset_i       (sw_reset_i),
  .stk_ovf_i        (stk_ovf_i),
  .stk_unf_i        (stk_unf_i),
  .flags_we_i       (flags_we_i),
  .core_rst_o       (core_rst_o),
  .flags_o          (flags_o)
);

// File: tb/rst_sequencer_tb.sv
module rst_sequencer_tb;
  localparam int FILT_LEN    = 8;
  localparam int PWRT_CYCLES = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic por = 0, bor = 0, prog_exit = 0, osc_ready = 1, pin_n = 1;
  logic cfg_pin_en = 1, cfg_lvp = 0, cfg_pwrt_en = 1, cfg_stk_en = 1;
  logic wdt = 0, swr = 0, ovf = 0, unf = 0, we = 0;
  logic [7:0] wdata = 8'h00;
  logic       core_rst;
  logic [7:0] flags;
  logic       pin_gpio;

  rst_sequencer #(
    .SYNC_STAGES (2),
    .FILT_LEN    (FILT_LEN),
    .PWRT_CYCLES (PWRT_CYCLES)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .por_i (por), .bor_i (bor),
    .prog_exit_i (prog_exit), .osc_ready_i (osc_ready), .pin_n_i (pin_n),
    .cfg_pin_en_i (cfg_pin_en), .cfg_lvp_i (cfg_lvp), .cfg_pwrt_en_i (cfg_pwrt_en),
    .cfg_stk_rst_en_i (cfg_stk_en), .wdt_timeout_i (wdt), .sw_reset_i (swr),
    .stk_ovf_i (ovf), .stk_unf_i (unf), .flags_we_i (we), .flags_wdata_i (wdata),
    .core_rst_o (core_rst), .flags_o (flags), .pin_is_gpio_o (pin_gpio)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag   = "R10";

  function automatic void chk(bit ok, string t, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endfunction

  // behavioural reference model
  bit       m_rst = 1;
  bit       m_done = 0;
  int       m_since = 0;
  bit       m_low = 0;
  int       m_run = 0;
  bit       m_pipe[$] = '{1'b1, 1'b1};
  bit [7:0] m_flags = 8'h3C;

  always @(posedge clk) begin
    bit s, cold, en, warm, hold;
    bit [7:0] f;
    if (!rst_ni) begin
      m_rst = 1; m_done = 0; m_since = 0; m_low = 0; m_run = 0;
      m_pipe = '{1'b1, 1'b1}; m_flags = 8'h3C;
    end else begin
      s    = m_pipe[0];
      cold = por || bor || prog_exit;
      en   = cfg_pin_en || cfg_lvp;
      warm = wdt || swr || (cfg_stk_en && (ovf || unf));
      hold = en && m_low && !s;
      m_rst = cold || warm || !m_done || !osc_ready || hold;
      f = we ? wdata : m_flags;
      if (por || prog_exit) f = 8'h3C;
      if (bor)  f[1] = 0;
      if (swr)  f[2] = 0;
      if (hold) f[3] = 0;
      if (wdt) begin f[4] = 0; f[5] = 1; end
      if (cfg_stk_en && ovf) f[6] = 1;
      if (cfg_stk_en && unf) f[7] = 1;
      m_flags = f;
      if (cold) begin m_since = 0; m_done = 0; end
      else if (!m_done) begin
        m_since++;
        m_done = !cfg_pwrt_en || m_since >= PWRT_CYCLES;
      end
      if (s) m_run = 0; else m_run++;
      m_low = !s && m_run >= FILT_LEN;
      void'(m_pipe.pop_front());
      m_pipe.push_back(pin_n);
    end
    #2;
    chk(core_rst === m_rst, {tag, " core_rst"}, core_rst, m_rst);
    chk(flags === m_flags, {tag, " flags"}, flags, m_flags);
    chk(pin_gpio === !(cfg_pin_en || cfg_lvp), "R1 pin_is_gpio", pin_gpio, !(cfg_pin_en || cfg_lvp));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    cyc(3);
    chk(core_rst == 1, "R4 reset holds core", core_rst, 1);
    chk(flags == 8'h3C, "R10 power-on flags", flags, 8'h3C);
    rst_ni = 1; tag = "R5";
    cyc(20);
    chk(core_rst == 1, "R5 delay running", core_rst, 1);
    cyc(30);
    chk(core_rst == 0, "R5 delay finished", core_rst, 0);

    tag = "R11";
    we = 1; wdata = 8'h3F; cyc(1); we = 0; cyc(2);
    chk(flags == 8'h3F, "R11 software write", flags, 8'h3F);

    tag = "R8";
    swr = 1; cyc(1); swr = 0; cyc(2);
    chk(flags[2] == 0, "R8 software reset flag", flags[2], 0);
    wdt = 1; cyc(1); wdt = 0; cyc(2);
    chk(flags[5:4] == 2'b10, "R10 watchdog flags", flags[5:4], 2);
    ovf = 1; cyc(1); ovf = 0; cyc(2);
    chk(flags[6] == 1, "R8 overflow flag", flags[6], 1);

    tag = "R9";
    we = 1; wdata = 8'h3F; cyc(1); we = 0;
    cfg_stk_en = 0; ovf = 1; unf = 1; cyc(1); ovf = 0; unf = 0; cyc(1);
    chk(core_rst == 0, "R9 disabled stack no reset", core_rst, 0);
    chk(flags[7:6] == 0, "R9 disabled stack no flag", flags[7:6], 0);
    cfg_stk_en = 1; cyc(2);

    tag = "R11";
    we = 1; wdata = 8'h3F; swr = 1; wdt = 1; unf = 1; cyc(1);
    we = 0; swr = 0; wdt = 0; unf = 0; cyc(1);
    chk(flags == 8'hAB, "R11 simultaneous causes", flags, 8'hAB);
    cyc(3);

    tag = "R2";
    we = 1; wdata = 8'h3F; cyc(1); we = 0;
    pin_n = 0; cyc(5); pin_n = 1; cyc(15);
    chk(core_rst == 0, "R2 short glitch ignored", core_rst, 0);
    pin_n = 0; cyc(7); pin_n = 1; cyc(15);
    chk(core_rst == 0 && flags[3] == 1, "R2 seven-cycle low ignored", core_rst, 0);
    pin_n = 0; cyc(30);
    chk(core_rst == 1, "R2 held low resets", core_rst, 1);
    chk(flags[3] == 0, "R2 pin flag", flags[3], 0);
    pin_n = 1; tag = "R7"; cyc(2);
    chk(core_rst == 1, "R7 two edges after release", core_rst, 1);
    cyc(1);
    chk(core_rst == 0, "R7 third edge releases", core_rst, 0);

    bor = 1; pin_n = 0; cyc(1); bor = 0; cyc(60);
    chk(core_rst == 1 && flags[1] == 0, "R7 pin held past delay", core_rst, 1);
    pin_n = 1; cyc(2);
    chk(core_rst == 1, "R7 hold until pin edge", core_rst, 1);
    cyc(1);
    chk(core_rst == 0, "R7 immediate start", core_rst, 0);

    tag = "R3";
    we = 1; wdata = 8'h3F; cyc(1); we = 0;
    cfg_pin_en = 0; cfg_lvp = 0; cyc(1);
    chk(pin_gpio == 1, "R1 both bits clear", pin_gpio, 1);
    pin_n = 0; cyc(30);
    chk(core_rst == 0 && flags[3] == 1, "R3 disabled pin ignored", core_rst, 0);
    pin_n = 1; cyc(4);
    cfg_lvp = 1; cyc(1);
    chk(pin_gpio == 0, "R1 lvp enables pin", pin_gpio, 0);
    cfg_lvp = 0; cfg_pin_en = 1; cyc(2);

    tag = "R6";
    osc_ready = 0; cyc(10);
    chk(core_rst == 1, "R6 oscillator not ready", core_rst, 1);
    osc_ready = 1; cyc(2);
    chk(core_rst == 0, "R6 oscillator ready", core_rst, 0);

    tag = "R4";
    we = 1; wdata = 8'hFF; cyc(1); we = 0;
    prog_exit = 1; cyc(1); prog_exit = 0; cyc(1);
    chk(flags == 8'h3C, "R4 programming exit as power-on", flags, 8'h3C);
    cyc(20);
    chk(core_rst == 1, "R4 full delay after programming exit", core_rst, 1);
    cyc(30);

    tag = "R5";
    cfg_pwrt_en = 0; cyc(1);
    bor = 1; cyc(1); bor = 0; cyc(1);
    chk(core_rst == 1, "R5 delay disabled, one edge", core_rst, 1);
    cyc(1);
    chk(core_rst == 0, "R5 delay disabled, released", core_rst, 0);
    cyc(5);

    summary();
    $finish;
  end
endmodule